// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the two lowest address bits of a four-beat burst for a synchronous cache memory. When a burst begins, it captures the full address. The upper part of the captured address is held in a register and driven out unchanged for the rest of the burst. The two lowest bits become the start of a two-bit beat sequence, and each cycle with the advance input active moves the sequence on by one beat.

Two address strobes can begin a burst: one driven by the processor and one driven by the cache controller. Both are active low. A run-time mode pin picks the order of the beats. The interleaved order XORs the start bits with the beat number. The linear order adds the beat number to the start bits and wraps within four.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, `upper_addr` reads 0 and `burst_addr` reads 0.
- R2: When `proc_strobe_n` is 0, `ctrl_strobe_n` is 0, or both are 0 at a rising edge, the address is captured. In the following cycle `upper_addr` equals the captured `addr_in[16:2]` and `burst_addr` equals the captured `addr_in[1:0]`, in either mode.
- R3: At a rising edge with both strobes at 1 and `adv_n` at 0, the beat number advances by one, modulo 4.
- R4: At a rising edge with both strobes at 1 and `adv_n` at 1, the beat number is held. `burst_addr` stays unchanged while `mode_il` stays unchanged.
- R5: With `mode_il` at 1 (interleaved), `burst_addr` equals the start bits XOR the beat number: for beats 0 to 3 the XOR values are 0, 1, 2, 3.
- R6: With `mode_il` at 0 (linear), `burst_addr` equals the start bits plus the beat number, modulo 4.
- R7: A strobe at 0 in the middle of a burst reloads the address and resets the beat number to 0. This happens even when `adv_n` is 0 in the same cycle.
- R8: After four advances, the beat number wraps back to 0 and `burst_addr` shows the start bits again.
- R9: `upper_addr` changes only at an edge where a strobe is 0. Advancing and holding leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_il | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_in | input | 17 | Full burst start address |
| upper_addr | output | 15 | Registered upper address bits |
| burst_addr | output | 2 | Sequenced low address bits |

## Verification
The assertions check the following on every cycle:
- a load presents the captured start address;
- the beat counter either steps by one or holds, and a strobe clears it;
- the upper address stays fixed without a strobe;
- in linear mode, each advance adds one to the output.

Only the bench's scenarios show:
- the full interleaved beat patterns for different start bits;
- the wrap back to the start after four beats;
- a restart in the middle of a burst;
- both strobes asserted together.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;
endpackage

// File: rtl/bsq_load_ctrl.sv
module bsq_load_ctrl (
   input  logic proc_strobe_n,
   input  logic ctrl_strobe_n,
   input  logic adv_n,
   output logic load,
   output logic step
);
   // A strobe always wins over advance; the processor strobe is checked first.
   always_comb begin
      load = 1'b0;
      step = 1'b0;
      if (!proc_strobe_n) begin
         load = 1'b1;
      end else if (!ctrl_strobe_n) begin
         load = 1'b1;
      end else if (!adv_n) begin
         step = 1'b1;
      end
   end
endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter #(
   parameter int ADDR_W  = 17,
   parameter int BURST_W = 2,
   localparam int UPPER_W = ADDR_W - BURST_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [ADDR_W-1:0]  addr_in,
   output logic [UPPER_W-1:0] upper_q,
   output logic [BURST_W-1:0] base_q,
   output logic [BURST_W-1:0] beat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         base_q  <= '0;
         beat_q  <= '0;
      end else if (load) begin
         upper_q <= addr_in[ADDR_W-1:BURST_W];
         base_q  <= addr_in[BURST_W-1:0];
         beat_q  <= '0;
      end else if (step) begin
         beat_q  <= beat_q + BURST_W'(1);
      end
   end

   // R7: a load restarts the beat count
   a_r7_load_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat_q == '0));

   // R3: an advance steps the beat count by one with wrap
   a_r3_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (beat_q == BURST_W'($past(beat_q) + BURST_W'(1))));

   // R4: no load and no step keeps the beat count
   a_r4_beat_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(beat_q) && $stable(base_q));
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
   import bsq_pkg::*;
#(
   parameter int BURST_W        = 2,
   parameter bit SUPPORT_LINEAR = 1'b1
) (
   input  logic [BURST_W-1:0] base,
   input  logic [BURST_W-1:0] beat,
   input  burst_order_e       order,
   output logic [BURST_W-1:0] addr_out
);
   logic [BURST_W-1:0] il_addr;

   // The interleaved order flips each start bit where the beat number has a one.
   for (genvar b = 0; b < BURST_W; b++) begin : g_xor
      assign il_addr[b] = base[b] ^ beat[b];
   end

   if (SUPPORT_LINEAR) begin : g_dual
      logic [BURST_W-1:0] lin_addr;
      assign lin_addr = base + beat;
      assign addr_out = (order == ORD_INTERLEAVE) ? il_addr : lin_addr;
   end else begin : g_il_only
      logic unused_order;
      assign unused_order = order;
      assign addr_out = il_addr;
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bsq_pkg::*;
#(
   parameter int ADDR_W         = 17,
   parameter int BURST_W        = 2,
   parameter bit SUPPORT_LINEAR = 1'b1,
   localparam int UPPER_W = ADDR_W - BURST_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               proc_strobe_n,
   input  logic               ctrl_strobe_n,
   input  logic               adv_n,
   input  logic               mode_il,
   input  logic [ADDR_W-1:0]  addr_in,
   output logic [UPPER_W-1:0] upper_addr,
   output logic [BURST_W-1:0] burst_addr
);
   if (BURST_W < 1) begin : g_bad_burst
      $error("BURST_W must be at least 1");
   end
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_W");
   end

   logic               load;
   logic               step;
   logic [BURST_W-1:0] base_q;
   logic [BURST_W-1:0] beat_q;
   burst_order_e       order;

   assign order = burst_order_e'(mode_il);

   bsq_load_ctrl u_load_ctrl (
      .proc_strobe_n (proc_strobe_n),
      .ctrl_strobe_n (ctrl_strobe_n),
      .adv_n         (adv_n),
      .load          (load),
      .step          (step)
   );

   bsq_beat_counter #(
      .ADDR_W  (ADDR_W),
      .BURST_W (BURST_W)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .addr_in (addr_in),
      .upper_q (upper_addr),
      .base_q  (base_q),
      .beat_q  (beat_q)
   );

   bsq_order_map #(
      .BURST_W        (BURST_W),
      .SUPPORT_LINEAR (SUPPORT_LINEAR)
   ) u_order_map (
      .base     (base_q),
      .beat     (beat_q),
      .order    (order),
      .addr_out (burst_addr)
   );

   // R2: either strobe presents the captured start address next cycle
   a_r2_load_presents_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n || !ctrl_strobe_n) |=>
         (burst_addr == $past(addr_in[BURST_W-1:0])) &&
         (upper_addr == $past(addr_in[ADDR_W-1:BURST_W])));

   // R9: upper address moves only on a strobe
   a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_strobe_n && ctrl_strobe_n) |=> $stable(upper_addr));

   // R4: holding with a steady mode keeps the output
   a_r4_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_strobe_n && ctrl_strobe_n && adv_n) |=>
         ($stable(mode_il) -> $stable(burst_addr)));

   // R6: in linear order each advance adds one
   if (SUPPORT_LINEAR) begin : g_lin_chk
      a_r6_linear_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
         (proc_strobe_n && ctrl_strobe_n && !adv_n && !mode_il) |=>
            (!mode_il -> (burst_addr == BURST_W'($past(burst_addr) + BURST_W'(1)))));
   end
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
   typedef struct {
      logic [14:0] up;
      logic [1:0]  ba;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        proc_strobe_n = 1'b1;
   logic        ctrl_strobe_n = 1'b1;
   logic        adv_n = 1'b1;
   logic        mode_il = 1'b1;
   logic [16:0] addr_in = '0;
   logic [14:0] upper_addr;
   logic [1:0]  burst_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t sb_q[$];

   logic [14:0] m_up   = '0;
   logic [1:0]  m_base = '0;
   logic [1:0]  m_beat = '0;

   always #5 clk = ~clk;

   burst_addr_seq u_burst_addr_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .proc_strobe_n (proc_strobe_n),
      .ctrl_strobe_n (ctrl_strobe_n),
      .adv_n         (adv_n),
      .mode_il       (mode_il),
      .addr_in       (addr_in),
      .upper_addr    (upper_addr),
      .burst_addr    (burst_addr)
   );

   task automatic compare(input string tag, input logic [14:0] up, input logic [1:0] ba);
      checks++;
      if (upper_addr !== up || burst_addr !== ba) begin
         fails++;
         $display("FAIL %s: upper=%h burst=%0d expected upper=%h burst=%0d",
                  tag, upper_addr, burst_addr, up, ba);
      end
   endtask

   // Driver: applies one cycle of stimulus and pushes the expected result.
   task automatic drive(input logic p_n, input logic c_n, input logic a_n,
                        input logic mode, input logic [16:0] addr, input string tag);
      exp_t e;
      @(negedge clk);
      proc_strobe_n = p_n;
      ctrl_strobe_n = c_n;
      adv_n         = a_n;
      mode_il       = mode;
      addr_in       = addr;
      @(posedge clk);
      #1;
      if (!p_n || !c_n) begin
         m_up   = addr[16:2];
         m_base = addr[1:0];
         m_beat = 2'd0;
      end else if (!a_n) begin
         m_beat = m_beat + 2'd1;
      end
      e.up  = m_up;
      e.ba  = mode ? (m_base ^ m_beat) : (m_base + m_beat);
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: pops each expected item once the design has produced it.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare(e.tag, e.up, e.ba);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #3;
      compare("R1 reset", 15'h0, 2'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 processor strobe, R5 interleaved beats, R8 wrap, R9 upper kept
      drive(1'b0, 1'b1, 1'b1, 1'b1, 17'h12345, "R2 proc load");
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0, "R5 il beat1");
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0, "R5 il beat2");
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0, "R9 il beat3");
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0, "R8 il wrap");
      // R4 hold
      drive(1'b1, 1'b1, 1'b1, 1'b1, 17'h1FFFF, "R4 hold a");
      drive(1'b1, 1'b1, 1'b1, 1'b1, 17'h0AAAA, "R4 hold b");
      // R2 controller strobe, R6 linear beats, R3 step
      drive(1'b1, 1'b0, 1'b1, 1'b0, 17'h0ABCE, "R2 ctrl load");
      drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h0, "R6 lin beat1");
      drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h0, "R6 lin beat2");
      drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h0, "R3 lin beat3");
      drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h0, "R8 lin wrap");
      // R2 both strobes
      drive(1'b0, 1'b0, 1'b1, 1'b1, 17'h1F00F, "R2 both load");
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0, "R5 il start3 beat1");
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0, "R5 il start3 beat2");
      // R7 restart mid-burst while advance is active
      drive(1'b1, 1'b0, 1'b0, 1'b1, 17'h00101, "R7 restart");
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0, "R7 after restart");
      drive(1'b0, 1'b1, 1'b0, 1'b0, 17'h15556, "R7 proc restart lin");
      drive(1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R4 lin hold");
      drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h0, "R6 lin start2 beat1");
      drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h0, "R6 lin start2 beat2");

      @(negedge clk);
      proc_strobe_n = 1'b1;
      ctrl_strobe_n = 1'b1;
      adv_n         = 1'b1;
      @(posedge clk);
      #3;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule